// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Sequencer

This block converts a single bus access aimed at a flash window into a complete single-bit SPI exchange with one of several flash devices. A small configuration port sets up each chip select. Each chip select has a control word with five fields: the access mode, the command byte, a dummy-byte count, a wide-address flag and a manual chip-select bit. A global word holds one write-enable bit for each chip select. The bus side offers address, write data, a byte count of 1 to 4, a direction bit and a valid/ready handshake. `bus_ready` pulses when the exchange is over. `bus_rdata` and `bus_err` are valid in that cycle.

There are four modes. In slow read, the command byte is always 0x03. In fast read, the command comes from the control word and is followed by a run of 0xFF dummy bytes. In write mode, data bytes follow the command and address. In raw mode, only the data bytes are shifted and the chip-select line follows the manual bit in the control word. The serial clock runs at half the system clock in SPI mode 0, and every byte is shifted most significant bit first.

Top module: `flash_xfer_seq`

## Requirements
- R1: After reset every `spi_cs_n` line is high, `spi_sclk` is low and `bus_ready` is low.
- R2: The serial clock idles low. It is high for exactly one system cycle per bit, so each bit takes two cycles. MOSI changes only while SCLK is low. Each byte gives eight SCLK rising edges and is sent bit 7 first.
- R3: Slow-read mode is mode value 0 in control bits [1:0]. It sends command 0x03 whatever bits [23:16] hold. It then sends address bits [23:16], [15:8] and [7:0], followed by the data bytes, and it sends no dummy bytes even when the dummy field is nonzero.
- R4: When control bit 13 is set, a fourth address byte, address bits [31:24], is sent ahead of the other three.
- R5: Fast-read mode is mode value 1. It sends the command byte from bits [23:16] and then N bytes of 0xFF before the data. N is the 3-bit number whose upper bit is control bit 14 and whose lower bits are bits [7:6].
- R6: Received data byte i lands in `bus_rdata[8i+7:8i]`, for 1 to 4 bytes per access. Unused upper bytes read zero.
- R7: Write mode is mode value 2. It sends the command from bits [23:16], then the address, then write-data bytes lowest byte first. `bus_rdata` reads zero.
- R8: Raw mode is mode value 3. It sends no command and no address. A write shifts out the data bytes, and a read shifts out 0x00 while sampling MISO. The chip-select line equals control bit 2 (1 means high) before, during and after the access.
- R9: A write to a chip select whose write-enable bit (global word bit 16 + index) is clear produces no SCLK edge and no chip-select change, and it returns `bus_err` = 1.
- R10: Three kinds of access produce no SPI activity, return zero data and set `bus_err`: a read in write mode, a write in either read mode, and a byte count of 0 or above 4.
- R11: In the three framed modes the chip select goes low before the first byte and is high again in the `bus_ready` cycle. Control bit 2 is left at 1 afterwards, even if it was 0 before the access.
- R12: `bus_ready` is high for exactly one cycle per access.
- R13: Configuration index 0 writes the global word. Index 1 + n writes the control word of chip select n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Configuration word index (0 global, 1+n control of CS n) |
| cfg_wdata | input | 32 | Configuration write data |
| bus_valid | input | 1 | Access request, held until `bus_ready` |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_cs | input | CS_W | Target chip select |
| bus_addr | input | 32 | Byte address inside the device |
| bus_wdata | input | 8*DATA_BYTES | Write data, lowest byte sent first |
| bus_size | input | SZ_W | Number of data bytes |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 8*DATA_BYTES | Read data, valid with `bus_ready` |
| bus_err | output | 1 | Access rejected, valid with `bus_ready` |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The hardest case to reach is a framed access that starts while software has already pulled the chip select low through control bit 2. After such an access, the line must rise and stay high. The stimulus clears that bit in slow-read mode, confirms that the line is low, and then issues a read. In raw mode it keeps the line low across a write and a read to show that the sequencer leaves it alone. Random runs add mixed modes, widths, dummy counts and enable bits, so that rejected accesses fall between good ones.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

   typedef enum logic [1:0] {
      MD_SLOW  = 2'd0,
      MD_FAST  = 2'd1,
      MD_WRITE = 2'd2,
      MD_RAW   = 2'd3
   } fseq_mode_e;

   localparam logic [7:0] OP_SLOW_READ = 8'h03;

   typedef struct packed {
      logic [7:0] opcode;
      logic [2:0] dummy;
      logic       wide_addr;
      logic       stop;
      fseq_mode_e mode;
   } fseq_ctrl_t;

   function automatic fseq_ctrl_t unpack_ctrl(input logic [31:0] w);
      fseq_ctrl_t c;
      c.opcode    = w[23:16];
      c.dummy     = {w[14], w[7:6]};
      c.wide_addr = w[13];
      c.stop      = w[2];
      c.mode      = fseq_mode_e'(w[1:0]);
      return c;
   endfunction

endpackage

// File: rtl/fseq_regs.sv
module fseq_regs
   import fseq_pkg::*;
#(
   parameter int NUM_CS   = 2,
   parameter int CS_SLOTS = 2,
   parameter int IDX_W    = 2,
   parameter int CS_W     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [31:0]       cfg_wdata,
   input  logic              stop_set,
   input  logic [CS_W-1:0]   stop_idx,
   output fseq_ctrl_t        ctrl_o    [CS_SLOTS],
   output logic [CS_SLOTS-1:0] wen_o,
   output logic [CS_SLOTS-1:0] present_o
);

   logic [NUM_CS-1:0] wen_q;
   logic [31:0]       unused_cfg;

   assign unused_cfg = cfg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen_q <= '0;
      end else if (cfg_wr && cfg_idx == '0) begin
         wen_q <= cfg_wdata[16 +: NUM_CS];
      end
   end

   for (genvar i = 0; i < CS_SLOTS; i++) begin : g_slot
      if (i < NUM_CS) begin : g_live
         fseq_ctrl_t q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q      <= '0;
               q.stop <= 1'b1;
            end else if (cfg_wr && cfg_idx == IDX_W'(i + 1)) begin
               q <= unpack_ctrl(cfg_wdata);
            end else if (stop_set && stop_idx == CS_W'(i)) begin
               q.stop <= 1'b1;
            end
         end
         assign ctrl_o[i]    = q;
         assign wen_o[i]     = wen_q[i];
         assign present_o[i] = 1'b1;
      end else begin : g_absent
         assign ctrl_o[i]    = '{opcode: 8'h00, dummy: 3'd0, wide_addr: 1'b0,
                                 stop: 1'b1, mode: MD_SLOW};
         assign wen_o[i]     = 1'b0;
         assign present_o[i] = 1'b0;
      end
   end

endmodule

// File: rtl/fseq_shift.sv
module fseq_shift (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx,
   input  logic       miso,
   output logic       sclk,
   output logic       mosi,
   output logic       busy,
   output logic       done,
   output logic [7:0] rx
);

   logic [7:0] sh_q;
   logic [2:0] bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         bit_q <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
         sclk  <= 1'b0;
         rx    <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            sh_q  <= tx;
            bit_q <= '0;
            busy  <= 1'b1;
            sclk  <= 1'b0;
         end else if (busy) begin
            if (!sclk) begin
               sclk <= 1'b1;
               rx   <= {rx[6:0], miso};
            end else begin
               sclk  <= 1'b0;
               sh_q  <= {sh_q[6:0], 1'b0};
               bit_q <= bit_q + 3'd1;
               if (bit_q == 3'd7) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            end
         end
      end
   end

   assign mosi = busy ? sh_q[7] : 1'b0;

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
   import fseq_pkg::*;
#(
   parameter int CS_SLOTS   = 2,
   parameter int CS_W       = 1,
   parameter int DATA_BYTES = 4,
   parameter int SZ_W       = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_valid,
   input  logic                    bus_write,
   input  logic [CS_W-1:0]         bus_cs,
   input  logic [31:0]             bus_addr,
   input  logic [8*DATA_BYTES-1:0] bus_wdata,
   input  logic [SZ_W-1:0]         bus_size,
   output logic                    bus_ready,
   output logic [8*DATA_BYTES-1:0] bus_rdata,
   output logic                    bus_err,
   input  fseq_ctrl_t              ctrl_i    [CS_SLOTS],
   input  logic [CS_SLOTS-1:0]     wen_i,
   input  logic [CS_SLOTS-1:0]     present_i,
   output logic                    sh_start,
   output logic [7:0]              sh_tx,
   input  logic                    sh_done,
   input  logic [7:0]              sh_rx,
   output logic                    frame_act,
   output logic [CS_W-1:0]         act_cs,
   output logic                    stop_set
);

   localparam int DW        = 8 * DATA_BYTES;
   localparam int BI_W      = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
   localparam int MAX_BYTES = 1 + 4 + 7 + DATA_BYTES;
   localparam int KW        = $clog2(MAX_BYTES + 1);

   typedef enum logic [2:0] {
      S_IDLE, S_SETUP, S_LOAD, S_SHIFT, S_HOLD, S_RESP
   } st_e;

   st_e             st_q;
   logic [CS_W-1:0] cs_q;
   logic [31:0]     addr_q;
   logic [DW-1:0]   wdata_q, rdata_q;
   logic            wr_q, wide_q, frame_q, err_q;
   logic [7:0]      op_q;
   logic [KW-1:0]   hdr_q, tot_q, k_q;

   // decode of the request against the selected control word
   fseq_ctrl_t    sel;
   logic          bad_d, frame_d;
   logic [KW-1:0] hdr_d, tot_d;
   logic [7:0]    op_d;

   always_comb begin
      sel     = ctrl_i[bus_cs];
      frame_d = (sel.mode != MD_RAW);
      bad_d   = !present_i[bus_cs]
             || (bus_size == '0)
             || (bus_size > SZ_W'(DATA_BYTES))
             || (bus_write && (!wen_i[bus_cs] || sel.mode == MD_SLOW || sel.mode == MD_FAST))
             || (!bus_write && sel.mode == MD_WRITE);
      hdr_d = '0;
      if (frame_d) begin
         hdr_d = KW'(1) + (sel.wide_addr ? KW'(4) : KW'(3))
               + ((sel.mode == MD_FAST) ? KW'(sel.dummy) : KW'(0));
      end
      tot_d = hdr_d + KW'(bus_size);
      op_d  = (sel.mode == MD_SLOW) ? OP_SLOW_READ : sel.opcode;
   end

   // byte selection for the current frame position
   logic [BI_W-1:0] didx;
   logic [2:0]      apos;
   logic            in_data, last;

   assign didx    = BI_W'(k_q - hdr_q);
   assign apos    = (wide_q ? 3'd4 : 3'd3) - 3'(k_q);
   assign in_data = !frame_q || (k_q >= hdr_q);
   assign last    = (KW'(k_q + KW'(1)) == tot_q);

   always_comb begin
      if (in_data) begin
         sh_tx = wr_q ? wdata_q[8*didx +: 8] : 8'h00;
      end else if (k_q == '0) begin
         sh_tx = op_q;
      end else if (k_q <= (wide_q ? KW'(4) : KW'(3))) begin
         sh_tx = addr_q[8*apos +: 8];
      end else begin
         sh_tx = 8'hFF;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         cs_q    <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         wr_q    <= 1'b0;
         wide_q  <= 1'b0;
         frame_q <= 1'b0;
         err_q   <= 1'b0;
         op_q    <= '0;
         hdr_q   <= '0;
         tot_q   <= '0;
         k_q     <= '0;
      end else begin
         case (st_q)
            S_IDLE: if (bus_valid) begin
               cs_q    <= bus_cs;
               addr_q  <= bus_addr;
               wdata_q <= bus_wdata;
               wr_q    <= bus_write;
               wide_q  <= sel.wide_addr;
               frame_q <= frame_d;
               op_q    <= op_d;
               hdr_q   <= hdr_d;
               tot_q   <= tot_d;
               k_q     <= '0;
               rdata_q <= '0;
               err_q   <= bad_d;
               if (bad_d)        st_q <= S_RESP;
               else if (frame_d) st_q <= S_SETUP;
               else              st_q <= S_LOAD;
            end
            S_SETUP: st_q <= S_LOAD;
            S_LOAD:  st_q <= S_SHIFT;
            S_SHIFT: if (sh_done) begin
               if (!wr_q && in_data) rdata_q[8*didx +: 8] <= sh_rx;
               k_q <= k_q + KW'(1);
               if (last) st_q <= frame_q ? S_HOLD : S_RESP;
               else      st_q <= S_LOAD;
            end
            S_HOLD:  st_q <= S_RESP;
            S_RESP:  st_q <= S_IDLE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign sh_start  = (st_q == S_LOAD);
   assign frame_act = frame_q && (st_q == S_SETUP || st_q == S_LOAD || st_q == S_SHIFT);
   assign act_cs    = cs_q;
   assign stop_set  = frame_q && (st_q == S_SHIFT) && sh_done && last;
   assign bus_ready = (st_q == S_RESP);
   assign bus_rdata = rdata_q;
   assign bus_err   = err_q;

endmodule

// File: rtl/flash_xfer_seq.sv
module flash_xfer_seq
   import fseq_pkg::*;
#(
   parameter int NUM_CS     = 2,
   parameter int DATA_BYTES = 4,
   localparam int CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int IDX_W     = $clog2(NUM_CS + 1),
   localparam int SZ_W      = $clog2(DATA_BYTES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_wr,
   input  logic [IDX_W-1:0]        cfg_idx,
   input  logic [31:0]             cfg_wdata,
   input  logic                    bus_valid,
   input  logic                    bus_write,
   input  logic [CS_W-1:0]         bus_cs,
   input  logic [31:0]             bus_addr,
   input  logic [8*DATA_BYTES-1:0] bus_wdata,
   input  logic [SZ_W-1:0]         bus_size,
   output logic                    bus_ready,
   output logic [8*DATA_BYTES-1:0] bus_rdata,
   output logic                    bus_err,
   output logic                    spi_sclk,
   output logic                    spi_mosi,
   input  logic                    spi_miso,
   output logic [NUM_CS-1:0]       spi_cs_n
);

   localparam int CS_SLOTS = 1 << CS_W;

   if (NUM_CS < 1 || NUM_CS > 16) begin : g_bad_cs
      $error("NUM_CS must lie in 1..16");
   end
   if (DATA_BYTES < 1 || DATA_BYTES > 4) begin : g_bad_bytes
      $error("DATA_BYTES must lie in 1..4");
   end

   fseq_ctrl_t          ctrl [CS_SLOTS];
   logic [CS_SLOTS-1:0] wen, present;
   logic                stop_set, frame_act;
   logic [CS_W-1:0]     act_cs;
   logic                sh_start, sh_done, sh_busy;
   logic [7:0]          sh_tx, sh_rx;

   fseq_regs #(
      .NUM_CS(NUM_CS), .CS_SLOTS(CS_SLOTS), .IDX_W(IDX_W), .CS_W(CS_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
      .stop_set(stop_set), .stop_idx(act_cs),
      .ctrl_o(ctrl), .wen_o(wen), .present_o(present)
   );

   fseq_ctrl #(
      .CS_SLOTS(CS_SLOTS), .CS_W(CS_W), .DATA_BYTES(DATA_BYTES), .SZ_W(SZ_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_cs(bus_cs),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_size(bus_size),
      .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .ctrl_i(ctrl), .wen_i(wen), .present_i(present),
      .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done), .sh_rx(sh_rx),
      .frame_act(frame_act), .act_cs(act_cs), .stop_set(stop_set)
   );

   fseq_shift u_shift (
      .clk(clk), .rst_n(rst_n),
      .start(sh_start), .tx(sh_tx), .miso(spi_miso),
      .sclk(spi_sclk), .mosi(spi_mosi),
      .busy(sh_busy), .done(sh_done), .rx(sh_rx)
   );

   logic unused_busy;
   assign unused_busy = sh_busy;

   for (genvar i = 0; i < NUM_CS; i++) begin : g_csn
      assign spi_cs_n[i] = (frame_act && act_cs == CS_W'(i)) ? 1'b0 : ctrl[i].stop;
   end

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
   parameter int NUM_CS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_ready,
   input logic              bus_err,
   input logic              spi_sclk,
   input logic              spi_mosi,
   input logic [NUM_CS-1:0] spi_cs_n
);

   logic        sclk_d;
   logic [15:0] rises;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         rises  <= '0;
      end else begin
         sclk_d <= spi_sclk;
         if (bus_ready)                        rises <= '0;
         else if (spi_sclk && !sclk_d && rises != 16'hFFFF) rises <= rises + 16'd1;
      end
   end

   AST_RESET_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (&spi_cs_n)); // R1

   AST_SCLK_ONE_CYCLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sclk |=> !spi_sclk); // R2

   AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sclk |-> $stable(spi_mosi)); // R2

   AST_SCLK_LOW_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |-> !spi_sclk); // R2

   AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ready && bus_err) |-> (rises == 16'd0)); // R10

   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |=> !bus_ready); // R12

endmodule

bind flash_xfer_seq fseq_chk #(.NUM_CS(NUM_CS)) u_fseq_chk (
   .clk(clk), .rst_n(rst_n), .bus_ready(bus_ready), .bus_err(bus_err),
   .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
);

// File: tb/flash_xfer_seq_test.sv
module flash_xfer_seq_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr;
   logic [1:0]  cfg_idx;
   logic [31:0] cfg_wdata;
   logic        bus_valid, bus_write;
   logic [0:0]  bus_cs;
   logic [31:0] bus_addr, bus_wdata;
   logic [2:0]  bus_size;
   logic        bus_ready, bus_err;
   logic [31:0] bus_rdata;
   logic        spi_sclk, spi_mosi, spi_miso;
   logic [1:0]  spi_cs_n;

   always #10 clk = ~clk;

   flash_xfer_seq uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_cs(bus_cs),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_size(bus_size),
      .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs_n(spi_cs_n)
   );

   int n_checks = 0;
   int n_fails  = 0;

   // flash device model: records MOSI bytes, returns a known byte stream
   int          ncap, nbit, nrise;
   logic [7:0]  cap [0:63];
   logic [7:0]  shreg;
   logic [1:0]  cs_low_seen;

   function automatic logic [7:0] resp(input int k);
      return 8'hC3 ^ 8'(k * 29);
   endfunction

   function automatic logic miso_of(input int k, input int b);
      logic [7:0] r;
      r = resp(k);
      return r[7 - b];
   endfunction

   assign spi_miso = miso_of(ncap, nbit);

   always @(posedge spi_sclk) begin
      shreg = {shreg[6:0], spi_mosi};
      nrise++;
      if (nbit == 7) begin
         if (ncap < 64) cap[ncap] = shreg;
         ncap++;
         nbit = 0;
      end else begin
         nbit++;
      end
   end

   always @(negedge clk) cs_low_seen |= ~spi_cs_n;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] cw(input int mode, input logic [7:0] op,
                                      input logic [2:0] dum, input bit wide,
                                      input bit stop);
      return {8'h00, op, 1'b0, dum[2], wide, 5'b0, dum[1:0], 3'b0, stop, 2'(mode)};
   endfunction

   // expected frame
   logic [7:0]  exp_b [0:31];
   int          nexp;
   logic [31:0] exp_rd;
   bit          exp_bad;

   task automatic model(input bit wr, input int mode, input bit we, input bit wide,
                        input logic [2:0] dum, input logic [7:0] op,
                        input logic [31:0] a, input logic [31:0] wd, input int sz);
      int hdr;
      exp_bad = (sz < 1) || (sz > 4) || (wr && (!we || mode < 2)) || (!wr && mode == 2);
      nexp    = 0;
      exp_rd  = '0;
      if (exp_bad) return;
      if (mode != 3) begin
         exp_b[nexp++] = (mode == 0) ? 8'h03 : op;
         if (wide) exp_b[nexp++] = a[31:24];
         exp_b[nexp++] = a[23:16];
         exp_b[nexp++] = a[15:8];
         exp_b[nexp++] = a[7:0];
         if (mode == 1) for (int d = 0; d < int'(dum); d++) exp_b[nexp++] = 8'hFF;
      end
      hdr = nexp;
      for (int j = 0; j < sz; j++) begin
         exp_b[nexp++] = wr ? wd[8*j +: 8] : 8'h00;
         if (!wr) exp_rd[8*j +: 8] = resp(hdr + j);
      end
   endtask

   task automatic cfg(input logic [1:0] idx, input logic [31:0] d);
      @(negedge clk);
      cfg_wr    = 1'b1;
      cfg_idx   = idx;
      cfg_wdata = d;
      @(negedge clk);
      cfg_wr    = 1'b0;
   endtask

   task automatic run(input bit wr, input bit cs, input int mode, input bit we,
                      input bit wide, input logic [2:0] dum, input logic [7:0] op,
                      input bit stop, input logic [31:0] a, input logic [31:0] wd,
                      input int sz);
      string       tag;
      logic [31:0] got_rd;
      bit          got_err, bytes_ok;
      logic [1:0]  cs_end;
      int          cyc;
      cfg(2'd0, 32'({cs ? we : 1'b1, cs ? 1'b1 : we}) << 16);
      cfg(2'(cs) + 2'd1, cw(mode, op, dum, wide, stop));
      model(wr, mode, we, wide, dum, op, a, wd, sz);
      if (exp_bad)        tag = (wr && !we) ? "R9" : "R10";
      else if (mode == 0) tag = wide ? "R4" : "R3";
      else if (mode == 1) tag = "R5";
      else if (mode == 2) tag = "R7";
      else                tag = "R8";
      @(negedge clk);
      ncap = 0; nbit = 0; nrise = 0; cs_low_seen = 2'b00;
      bus_valid = 1'b1; bus_write = wr; bus_cs = cs; bus_addr = a;
      bus_wdata = wd; bus_size = 3'(sz);
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!bus_ready && cyc < 3000);
      got_rd  = bus_rdata;
      got_err = bus_err;
      cs_end  = spi_cs_n;
      bus_valid = 1'b0;
      chk(cyc < 3000, {tag, " R12 ready seen"}, 64'(cyc), 64'(3000));
      chk(got_err == exp_bad, {tag, " err flag"}, 64'(got_err), 64'(exp_bad));
      chk(got_rd == exp_rd, {tag, " R6 read data"}, 64'(got_rd), 64'(exp_rd));
      chk(ncap == nexp, {tag, " byte count"}, 64'(ncap), 64'(nexp));
      bytes_ok = (ncap == nexp);
      for (int i = 0; i < nexp && i < 64; i++) if (cap[i] !== exp_b[i]) bytes_ok = 1'b0;
      chk(bytes_ok, {tag, " frame bytes"}, 64'(bytes_ok), 64'(1));
      chk(nrise == 8 * nexp, {tag, " R2 clock edges"}, 64'(nrise), 64'(8 * nexp));
      if (!exp_bad && mode != 3) begin
         chk(cs_end[cs] == 1'b1, {tag, " R11 cs released"}, 64'(cs_end), 64'(1));
         chk(cs_low_seen[cs] == 1'b1, {tag, " R11 cs asserted"}, 64'(cs_low_seen), 64'(1));
      end
      if (exp_bad && stop)
         chk(cs_low_seen == 2'b00, {tag, " cs untouched"}, 64'(cs_low_seen), 64'(0));
      @(negedge clk);
      chk(!bus_ready, "R12 ready one cycle", 64'(bus_ready), 64'(0));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL R12 watchdog expired: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      ncap = 0; nbit = 0; nrise = 0; shreg = '0; cs_low_seen = '0;
      rst_n = 1'b0; cfg_wr = 1'b0; cfg_idx = '0; cfg_wdata = '0;
      bus_valid = 1'b0; bus_write = 1'b0; bus_cs = '0; bus_addr = '0;
      bus_wdata = '0; bus_size = 3'd1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(spi_cs_n == 2'b11, "R1 cs after reset", 64'(spi_cs_n), 64'(3));
      chk(!spi_sclk && !bus_ready, "R1 sclk/ready after reset",
          64'({spi_sclk, bus_ready}), 64'(0));

      // R3: slow read ignores opcode field and dummy field
      run(0, 0, 0, 1, 0, 3'd5, 8'hAB, 1, 32'h9912_3456, 32'h0, 4);
      // R4: four-byte address
      run(0, 1, 0, 1, 1, 3'd0, 8'h00, 1, 32'hA1B2_C3D4, 32'h0, 2);
      // R5: fast read with dummy from bit 14 and bits 7:6
      run(0, 0, 1, 1, 0, 3'd5, 8'h0B, 1, 32'h0000_0100, 32'h0, 3);
      run(0, 1, 1, 1, 1, 3'd0, 8'h0C, 1, 32'h0102_0304, 32'h0, 1);
      // R7: write mode
      run(1, 1, 2, 1, 0, 3'd0, 8'h02, 1, 32'h0004_0010, 32'hDDCC_BBAA, 3);
      // R9: write enable clear
      run(1, 0, 2, 0, 0, 3'd0, 8'h02, 1, 32'h10, 32'h1234_5678, 4);
      // R10: illegal combinations and sizes
      run(0, 0, 2, 1, 0, 3'd0, 8'h02, 1, 32'h10, 32'h0, 4);
      run(1, 0, 0, 1, 0, 3'd0, 8'h02, 1, 32'h10, 32'h55, 1);
      run(1, 1, 1, 1, 0, 3'd2, 8'h0B, 1, 32'h10, 32'h55, 1);
      run(0, 0, 0, 1, 0, 3'd0, 8'h00, 1, 32'h10, 32'h0, 0);
      run(0, 0, 0, 1, 0, 3'd0, 8'h00, 1, 32'h10, 32'h0, 5);

      // R8: raw mode with manual chip select held low
      cfg(2'd1, cw(3, 8'h00, 3'd0, 0, 0));
      chk(spi_cs_n[0] == 1'b0, "R8 manual cs low", 64'(spi_cs_n), 64'(2));
      run(1, 0, 3, 1, 0, 3'd0, 8'h00, 0, 32'h0, 32'h0000_9F06, 2);
      chk(spi_cs_n[0] == 1'b0, "R8 cs kept after write", 64'(spi_cs_n), 64'(2));
      run(0, 0, 3, 1, 0, 3'd0, 8'h00, 0, 32'h0, 32'h0, 3);
      chk(spi_cs_n[0] == 1'b0, "R8 cs kept after read", 64'(spi_cs_n), 64'(2));
      cfg(2'd1, cw(3, 8'h00, 3'd0, 0, 1));
      chk(spi_cs_n[0] == 1'b1, "R8 manual cs high", 64'(spi_cs_n), 64'(3));

      // R11: framed access after manual low leaves the line high
      cfg(2'd1, cw(0, 8'h00, 3'd0, 0, 0));
      chk(spi_cs_n[0] == 1'b0, "R13 control index 1 reaches cs0", 64'(spi_cs_n), 64'(2));
      run(0, 0, 0, 1, 0, 3'd0, 8'h00, 0, 32'h77, 32'h0, 1);
      repeat (2) @(negedge clk);
      chk(spi_cs_n[0] == 1'b1, "R11 stop bit left set", 64'(spi_cs_n), 64'(3));

      // random mix
      void'($urandom(32'd1357));
      for (int it = 0; it < 48; it++) begin
         int          md, sz;
         bit          wr, we, wide, cs;
         logic [2:0]  dum;
         logic [7:0]  op;
         logic [31:0] a, wd;
         md   = int'($urandom % 4);
         wr   = 1'($urandom % 2);
         we   = ($urandom % 5) != 0;
         wide = 1'($urandom % 2);
         cs   = 1'($urandom % 2);
         dum  = 3'($urandom % 8);
         op   = 8'($urandom);
         a    = $urandom;
         wd   = $urandom;
         sz   = 1 + int'($urandom % 4);
         run(wr, cs, md, we, wide, dum, op, 1, a, wd, sz);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule